// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up counter, four bits wide by default, with a parallel preset, an active-low clear and two count-enable inputs. Every state bit is held in flops on one clock, so all bits change together on the rising edge. No bit clocks another. One enable, `cnt_gate`, controls only whether the count advances. The other enable, `chain_in`, also controls the carry output. A stage can therefore be placed in a chain: its carry feeds the `chain_in` of the next stage, and all stages share one clock. The chain then counts as a single wide synchronous counter with no extra logic between stages.

The parameter `ASYNC_CLEAR` selects how the clear acts. With 1, the clear resets the count at once and does not wait for the clock. With 0, the clear is sampled on the rising edge like the other controls. In that mode a decode of a chosen terminal count can be fed back into `clear_n` to shorten the count sequence, which gives a divide-by-N counter.

Top module: `sync_preset_counter`

## Requirements
- R1: All bits of `count` change together on the rising edge of `clk`, and at no other time except for an asynchronous clear.
- R2: When `load_n` is 0 and no clear is active, `count` takes `preset` on the next rising edge, whatever the values of `cnt_gate` and `chain_in`.
- R3: With `ASYNC_CLEAR`=1, `clear_n` at 0 forces `count` to 0 right away, before any clock edge. While it stays 0, `count` stays 0 whatever the values of `load_n` and both enables.
- R4: With `ASYNC_CLEAR`=0, `clear_n` at 0 leaves `count` unchanged until the next rising edge, which sets it to 0 whatever the values of the enables.
- R5: `count` rises by one on a rising edge only when `cnt_gate` and `chain_in` are both 1, `load_n` is 1 and `clear_n` is 1.
- R6: When `clear_n` and `load_n` are both 1 and at least one enable is 0, `count` keeps its value across the edge.
- R7: Counting from the all-ones value wraps `count` to all zeros.
- R8: `carry` is 1 exactly when `chain_in` is 1 and `count` is all ones. `cnt_gate` has no effect on it, and it follows `chain_in` without waiting for a clock edge.
- R9: Three stages, each with its `carry` driving the next stage's `chain_in`, form a 12-bit synchronous counter. At 0xFFF the top carry is 1, and the next count is 0x000.
- R10: With `ASYNC_CLEAR`=0, feeding a decode of count 9 back into `clear_n` makes the counter repeat the sequence 0 to 9.
- R11: Clear has priority over load, load over counting, and counting over hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear, asynchronous or synchronous depending on `ASYNC_CLEAR` |
| load_n | input | 1 | Active-low synchronous preset |
| cnt_gate | input | 1 | Count enable that does not affect the carry |
| chain_in | input | 1 | Count enable that also qualifies the carry |
| preset | input | WIDTH | Value loaded into the counter |
| count | output | WIDTH | Current count |
| carry | output | 1 | High when `chain_in` is 1 and the count is all ones |

## Verification
The bench builds the counter with WIDTH=4 in both clear modes and drives both copies with the same stimulus. This exposes the one cycle of difference in clear timing: the asynchronous copy reads zero before the edge, and the synchronous copy still holds its old value. A separate copy with `ASYNC_CLEAR`=0 has a decode of count 9 wired back into its clear, which exercises the shortened sequence. Three more copies are chained through their carries into a 12-bit counter, so the carry across both stage boundaries at 0x0FF and 0xFFF can be observed.

// File: rtl/sync_counter_pkg.sv
package sync_counter_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } count_op_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic gate;
        logic chain;
    } count_ctrl_t;

    function automatic count_ctrl_t make_ctrl(logic clear_n, logic load_n,
                                              logic gate, logic chain);
        count_ctrl_t c;
        c.clear = ~clear_n;
        c.load  = ~load_n;
        c.gate  = gate;
        c.chain = chain;
        return c;
    endfunction

    function automatic logic run_enabled(count_ctrl_t c);
        return c.gate & c.chain;
    endfunction

endpackage

// File: rtl/counter_op_decode.sv
module counter_op_decode
    import sync_counter_pkg::*;
#(
    parameter bit SYNC_CLEAR = 1'b0
) (
    input  count_ctrl_t ctrl,
    output count_op_e   op
);

    always_comb begin
        if (SYNC_CLEAR && ctrl.clear) begin
            op = OP_CLEAR;
        end else if (ctrl.load) begin
            op = OP_LOAD;
        end else if (run_enabled(ctrl)) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

    // R11: load never beats an asserted synchronous clear
    always_comb begin
        if (SYNC_CLEAR && ctrl.clear && ctrl.load) begin
            p_clear_over_load_r11: assert (op == OP_CLEAR)
                else $error("load won over synchronous clear");
        end
    end

endmodule

// File: rtl/counter_state_reg.sv
module counter_state_reg
    import sync_counter_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clear_n,
    input  count_op_e        op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_CLEAR: q_next = ZERO;
            OP_LOAD:  q_next = preset;
            OP_COUNT: q_next = q + ONE;
            default:  q_next = q;
        endcase
    end

    generate
        if (ASYNC_CLEAR) begin : g_async
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) q <= ZERO;
                else          q <= q_next;
            end

            // R3: a held asynchronous clear keeps the state at zero
            always @(posedge clk) begin
                if (clear_n === 1'b0) begin
                    p_async_clear_r3: assert (q == ZERO)
                        else $error("state not zero under async clear");
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= q_next;
            end

            logic clr_seen_q;
            logic clr_prev_q;
            always_ff @(posedge clk) begin
                clr_seen_q <= 1'b1;
                clr_prev_q <= clear_n;
            end
            initial clr_seen_q = 1'b0;

            // R4: a clear sampled at the previous edge left zero behind
            always @(posedge clk) begin
                if (clr_seen_q === 1'b1 && clr_prev_q === 1'b0) begin
                    p_sync_clear_r4: assert (q == ZERO)
                        else $error("state not zero after sync clear");
                end
            end
        end
    endgenerate

endmodule

// File: rtl/counter_carry_gen.sv
module counter_carry_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain,
    output logic             carry
);

    logic full;

    always_comb begin
        full = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            full = full & q[i];
        end
        carry = chain & full;
    end

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import sync_counter_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             cnt_gate,
    input  logic             chain_in,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             carry
);

    localparam bit SYNC_CLEAR = !ASYNC_CLEAR;

    count_ctrl_t ctrl;
    count_op_e   op;

    assign ctrl = make_ctrl(clear_n, load_n, cnt_gate, chain_in);

    counter_op_decode #(
        .SYNC_CLEAR(SYNC_CLEAR)
    ) u_decode (
        .ctrl(ctrl),
        .op  (op)
    );

    counter_state_reg #(
        .WIDTH      (WIDTH),
        .ASYNC_CLEAR(ASYNC_CLEAR)
    ) u_state (
        .clk    (clk),
        .clear_n(clear_n),
        .op     (op),
        .preset (preset),
        .q      (count)
    );

    counter_carry_gen #(
        .WIDTH(WIDTH)
    ) u_carry (
        .q    (count),
        .chain(chain_in),
        .carry(carry)
    );

    p_load_r2: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> count == $past(preset))
        else $error("preset not taken");

    p_count_r5: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cnt_gate && chain_in) |=> count == $past(count) + WIDTH'(1))
        else $error("count did not advance");

    p_hold_r6: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(cnt_gate && chain_in)) |=> $stable(count))
        else $error("count moved while held");

    p_carry_needs_chain_r8: assert property (@(posedge clk) disable iff (!clear_n)
        carry |-> (chain_in && (count == {WIDTH{1'b1}})))
        else $error("carry without full count and chain enable");

endmodule

// File: tb/sync_preset_counter_test.sv
module counter_chain3 (
    input  logic        clk,
    input  logic        load_n,
    input  logic        run,
    input  logic [11:0] preset,
    output logic [11:0] value,
    output logic        top_carry
);
    logic [3:0] link;
    assign link[0] = run;

    for (genvar s = 0; s < 3; s++) begin : g_stage
        sync_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_stage (
            .clk     (clk),
            .clear_n (1'b1),
            .load_n  (load_n),
            .cnt_gate(run),
            .chain_in(link[s]),
            .preset  (preset[4*s +: 4]),
            .count   (value[4*s +: 4]),
            .carry   (link[s+1])
        );
    end

    assign top_carry = link[3];
endmodule

module sync_preset_counter_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic       clr_n = 1'b0;
    logic       ld_n  = 1'b1;
    logic       ep    = 1'b0;
    logic       et    = 1'b0;
    logic [3:0] d     = 4'h0;
    logic [3:0] q_a, q_s;
    logic       c_a, c_s;
    logic [3:0] ref_q = 4'h0;

    sync_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) uut (
        .clk(clk), .clear_n(clr_n), .load_n(ld_n), .cnt_gate(ep),
        .chain_in(et), .preset(d), .count(q_a), .carry(c_a));

    sync_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) uut_sync (
        .clk(clk), .clear_n(clr_n), .load_n(ld_n), .cnt_gate(ep),
        .chain_in(et), .preset(d), .count(q_s), .carry(c_s));

    logic       div_go = 1'b0;
    logic [3:0] q_div;
    logic       c_div;
    logic       div_clr_n;
    assign div_clr_n = div_go & (q_div != 4'd9);

    sync_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) uut_div (
        .clk(clk), .clear_n(div_clr_n), .load_n(1'b1), .cnt_gate(1'b1),
        .chain_in(1'b1), .preset(4'h0), .count(q_div), .carry(c_div));

    logic        k_ld_n = 1'b1;
    logic        k_run  = 1'b0;
    logic [11:0] k_d    = 12'h0;
    logic [11:0] k_q;
    logic        k_c;

    counter_chain3 uut_chain (
        .clk(clk), .load_n(k_ld_n), .run(k_run), .preset(k_d),
        .value(k_q), .top_carry(k_c));

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model(logic [3:0] q, logic cl_n, logic l_n,
                                         logic p, logic t, logic [3:0] v);
        if (!cl_n)      return 4'h0;
        else if (!l_n)  return v;
        else if (p & t) return q + 4'h1;
        else            return q;
    endfunction

    task automatic step(string req, logic cl_n, logic l_n, logic p, logic t,
                        logic [3:0] v);
        @(negedge clk);
        clr_n = cl_n; ld_n = l_n; ep = p; et = t; d = v;
        @(posedge clk);
        #1;
        ref_q = model(ref_q, cl_n, l_n, p, t, v);
        check(req, {12'h0, q_a}, {12'h0, ref_q});
        check(req, {12'h0, q_s}, {12'h0, ref_q});
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        check("R3 reset", {12'h0, q_a}, 16'h0);
        check("R4 reset", {12'h0, q_s}, 16'h0);
        step("R1 first edge", 1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic t_load;
        step("R2 load enables low", 1'b1, 1'b0, 1'b0, 1'b0, 4'hA);
        step("R2 load enables high", 1'b1, 1'b0, 1'b1, 1'b1, 4'h3);
        step("R2 load P only", 1'b1, 1'b0, 1'b1, 1'b0, 4'h6);
    endtask

    task automatic t_count_hold;
        step("R5 count", 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
        step("R5 count", 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
        step("R6 hold P low", 1'b1, 1'b1, 1'b0, 1'b1, 4'hF);
        step("R6 hold T low", 1'b1, 1'b1, 1'b1, 1'b0, 4'hF);
        step("R6 hold both low", 1'b1, 1'b1, 1'b0, 1'b0, 4'hF);
        check("R5 value after two counts", {12'h0, q_a}, 16'h8);
    endtask

    task automatic t_wrap_carry;
        step("R7 preload", 1'b1, 1'b0, 1'b0, 1'b0, 4'hE);
        step("R7 to 15", 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
        check("R8 carry at 15", {15'h0, c_a}, 16'h1);
        @(negedge clk); ep = 1'b0; #0.5;
        check("R8 carry ignores P", {15'h0, c_s}, 16'h1);
        et = 1'b0; #0.5;
        check("R8 carry drops with T", {15'h0, c_a}, 16'h0);
        et = 1'b1; #0.5;
        check("R8 carry rises with T", {15'h0, c_a}, 16'h1);
        step("R7 wrap", 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
        check("R7 wrapped to 0", {12'h0, q_a}, 16'h0);
        check("R8 carry low at 0", {15'h0, c_a}, 16'h0);
    endtask

    task automatic t_clear;
        step("R11 preload", 1'b1, 1'b0, 1'b0, 1'b0, 4'h9);
        @(negedge clk);
        #1;
        clr_n = 1'b0; ld_n = 1'b0; ep = 1'b1; et = 1'b1; d = 4'h5;
        #0.5;
        check("R3 async clear before edge", {12'h0, q_a}, 16'h0);
        check("R4 sync clear waits", {12'h0, q_s}, 16'h9);
        @(posedge clk);
        #1;
        ref_q = 4'h0;
        check("R11 clear beats load async", {12'h0, q_a}, 16'h0);
        check("R4 R11 clear beats load sync", {12'h0, q_s}, 16'h0);
        step("R3 R11 clear held", 1'b0, 1'b0, 1'b1, 1'b1, 4'h7);
        step("R11 release to load", 1'b1, 1'b0, 1'b1, 1'b1, 4'h7);
    endtask

    task automatic t_divider;
        logic [3:0] exp_div;
        @(negedge clk);
        div_go = 1'b1;
        exp_div = 4'h0;
        for (int i = 0; i < 25; i++) begin
            @(posedge clk);
            #1;
            exp_div = (exp_div == 4'd9) ? 4'd0 : exp_div + 4'd1;
            check("R10 divide by ten", {12'h0, q_div}, {12'h0, exp_div});
        end
    endtask

    task automatic t_chain;
        @(negedge clk);
        k_ld_n = 1'b0; k_d = 12'h0FE; k_run = 1'b0;
        @(negedge clk);
        k_ld_n = 1'b1; k_run = 1'b1;
        check("R9 chain loaded", {4'h0, k_q}, 16'h0FE);
        @(negedge clk);
        check("R9 chain 0x0FF", {4'h0, k_q}, 16'h0FF);
        check("R9 no top carry at 0x0FF", {15'h0, k_c}, 16'h0);
        @(negedge clk);
        check("R9 carry across two stages", {4'h0, k_q}, 16'h100);
        k_ld_n = 1'b0; k_d = 12'hFFE;
        @(negedge clk);
        k_ld_n = 1'b1;
        @(negedge clk);
        check("R9 chain 0xFFF", {4'h0, k_q}, 16'hFFF);
        check("R9 top carry at 0xFFF", {15'h0, k_c}, 16'h1);
        @(negedge clk);
        check("R9 chain wraps", {4'h0, k_q}, 16'h000);
        check("R9 top carry clear", {15'h0, k_c}, 16'h0);
        k_run = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_count_hold();
        t_wrap_carry();
        t_clear();
        t_divider();
        t_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule